// File: doc/BRIEF.md
# Character and Nametable Bank Selector

This block maps the picture processor's lower 12 KB (addresses $0000-$2FFF) onto external memory in twelve 1 KB windows. Eight windows cover pattern-table space and four cover nametable space. Each window has its own 8-bit bank register, written by the CPU. A bank value either names a 1 KB page of character ROM or sends the window to the console's internal nametable RAM, using one of its two pages.

The CPU writes the bank registers through a 2 KB-aligned decode in the $8000-$DFFF range. Two control bits come from a write to $E800-$EFFF, and this block keeps its own copy of them. Each bit turns off the RAM redirect for one half of pattern space. The selection from the picture processor address to the memory controls is purely combinational, so the outputs settle within the same access.

Top module: `chr_bank_selector`

## Requirements
- R1: After a synchronous active-low reset, every bank register holds $00 and both redirect-disable bits are clear. Every window then selects ROM page $00, with `rom_sel`=1 and `ntram_sel`=0.
- R2: A write with `cpu_we`=1 to CPU address $8000 + k·$800 (k = 0..11) loads `cpu_data` into the register of window k. The window shows the new value from the first clock edge after the write.
- R3: Every address inside a register's 2 KB span (for example $87FF for window 0) reaches that same register.
- R4: A bank value from $00 to $DF selects ROM in any window: `rom_sel`=1, `ntram_sel`=0, and `rom_page` equals the value.
- R5: A bank value from $E0 to $FF in a pattern window whose redirect is enabled selects internal RAM: `ntram_sel`=1 and `rom_sel`=0. `ntram_a10` equals bit 0 of the value (0 = page A, 1 = page B).
- R6: A write to $E800-$EFFF latches data bit 6 as the disable for windows 0-3 and data bit 7 as the disable for windows 4-7. In a disabled half, values $E0-$FF select ROM page equal to the value, which is one of the last 32 pages. Each half is controlled independently.
- R7: Nametable windows 8-11 always redirect values $E0-$FF to internal RAM, whatever the disable bits hold.
- R8: The window index is PPU A12:A10 when A13=0. When A13=1 it is 8 + A11:A10, with A12 ignored, so $3000-$3FFF uses the same windows as $2000-$2FFF.
- R9: The following writes change no bank register and no disable bit: writes with `cpu_we`=0, writes below $8000, and writes at $E000-$E7FF or $F000-$FFFF. A write to $E800 changes only the two disable bits and no bank register.
- R10: The outputs follow a change of `ppu_addr` within the same cycle, with no clock edge needed.
- R11: Exactly one of `rom_sel` and `ntram_sel` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | Picture processor address |
| rom_page | output | 8 | Character ROM address bits 17:10 |
| rom_sel | output | 1 | Character ROM selected |
| ntram_sel | output | 1 | Internal nametable RAM selected |
| ntram_a10 | output | 1 | Internal RAM page select (0 = A, 1 = B) |

## Verification
The assertions check the following on every cycle:
- exactly one target is selected;
- a decoded write lands in the addressed register;
- registers hold when no decoded write occurs;
- the disable bits latch data bits 6 and 7;
- low bank values always route to ROM;
- nametable windows always redirect high values.

Only the bench scenarios can show the following:
- the address-to-window mapping, including the $3000 mirror and the 2 KB aliasing of the register decode;
- the independence of the two pattern halves under each combination of disable bits;
- same-cycle response to a PPU address change.

// File: rtl/chr_bank_pkg.sv
// Shared widths, counts and types for the character/nametable bank selector.
// Assumes twelve 1 KB windows: eight pattern windows, then four nametable windows.
package chr_bank_pkg;
    localparam int PAGE_W    = 8;
    localparam int NUM_PAT   = 8;
    localparam int NUM_NT    = 4;
    localparam int NUM_WIN   = NUM_PAT + NUM_NT;
    localparam int WIN_IDX_W = $clog2(NUM_WIN);
    localparam int CPU_AW    = 16;
    localparam int PPU_AW    = 14;

    typedef logic [PAGE_W-1:0]    page_t;
    typedef logic [WIN_IDX_W-1:0] win_idx_t;

    localparam page_t    REDIRECT_BASE = page_t'(8'hE0);
    localparam win_idx_t LAST_WIN      = win_idx_t'(NUM_WIN - 1);
    localparam win_idx_t FIRST_NT_WIN  = win_idx_t'(NUM_PAT);
    localparam win_idx_t HALF_PAT      = win_idx_t'(NUM_PAT / 2);
    // CPU A15:A11 of the control register holding the two disable bits
    localparam logic [4:0] CTRL_SPAN   = 5'b11101;
endpackage

// File: rtl/chr_bank_regfile.sv
// Bank register file: decodes CPU writes into twelve per-window registers and
// latches the two pattern-half redirect-disable bits.
// Assumes each register owns a 2 KB span starting at $8000; bus writes are
// single-cycle strobes qualified by cpu_we.
module chr_bank_regfile
    import chr_bank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_we,
    input  logic [CPU_AW-1:0]          cpu_addr,
    input  logic [PAGE_W-1:0]          cpu_data,
    output logic [NUM_WIN-1:0][PAGE_W-1:0] bank_q,
    output logic                       dis_lo_q,
    output logic                       dis_hi_q
);
    logic     bank_hit;
    logic     ctrl_hit;
    win_idx_t wr_idx;

    // Decode which register, if any, the current write targets.
    always_comb begin
        wr_idx   = win_idx_t'(cpu_addr[14:11]);
        bank_hit = cpu_we && cpu_addr[15] && (wr_idx <= LAST_WIN);
        ctrl_hit = cpu_we && (cpu_addr[15:11] == CTRL_SPAN);
    end

    // One register per window, loaded when its span is written.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[w] <= '0;
            else if (bank_hit && (wr_idx == win_idx_t'(w)))
                bank_q[w] <= cpu_data;
        end
    end

    // Local copy of the redirect-disable bits from the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_lo_q <= 1'b0;
            dis_hi_q <= 1'b0;
        end else if (ctrl_hit) begin
            dis_lo_q <= cpu_data[6];
            dis_hi_q <= cpu_data[7];
        end
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr[15] && cpu_addr[14:11] <= 4'(NUM_WIN - 1))
        |=> bank_q[$past(cpu_addr[14:11])] == $past(cpu_data));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_we || !cpu_addr[15] || cpu_addr[14:11] > 4'(NUM_WIN - 1))
        |=> $stable(bank_q));

    p_ctrl_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr[15:11] == 5'b11101)
        |=> (dis_lo_q == $past(cpu_data[6])) && (dis_hi_q == $past(cpu_data[7])));
endmodule

// File: rtl/chr_window_select.sv
// Window index decode: turns a picture processor address into one of the
// twelve window numbers. Assumes A13=1 addresses nametable space, with A12
// ignored so that $3000-$3FFF reuses the nametable windows.
module chr_window_select
    import chr_bank_pkg::*;
(
    input  logic [PPU_AW-1:0] ppu_addr,
    output win_idx_t          win_idx
);
    // Pattern space uses A12:A10; nametable space offsets A11:A10 past the pattern windows.
    always_comb begin
        if (ppu_addr[13])
            win_idx = FIRST_NT_WIN + win_idx_t'(ppu_addr[11:10]);
        else
            win_idx = win_idx_t'(ppu_addr[12:10]);
    end
endmodule

// File: rtl/chr_bank_route.sv
// Target routing: chooses character ROM or internal nametable RAM for the
// selected window's bank value. Assumes values at or above REDIRECT_BASE are
// redirect candidates, with bit 0 choosing the RAM page.
module chr_bank_route
    import chr_bank_pkg::*;
(
    input  page_t    bank,
    input  win_idx_t win_idx,
    input  logic     dis_lo,
    input  logic     dis_hi,
    output page_t    rom_page,
    output logic     rom_sel,
    output logic     ntram_sel,
    output logic     ntram_a10
);
    logic high_val;
    logic allowed;

    // Decide whether this window may redirect, then whether this value does.
    always_comb begin
        high_val = (bank >= REDIRECT_BASE);
        if (win_idx >= FIRST_NT_WIN)
            allowed = 1'b1;
        else if (win_idx < HALF_PAT)
            allowed = !dis_lo;
        else
            allowed = !dis_hi;
        ntram_sel = high_val && allowed;
        rom_sel   = !ntram_sel;
        rom_page  = bank;
        ntram_a10 = bank[0];
    end
endmodule

// File: rtl/chr_bank_selector.sv
// Top of the character/nametable bank selector: CPU-written bank registers,
// combinational PPU address decode and target routing. Assumes the PPU
// address is stable for the duration of an access; no output is registered.
module chr_bank_selector
    import chr_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic [13:0] ppu_addr,
    output logic [7:0]  rom_page,
    output logic        rom_sel,
    output logic        ntram_sel,
    output logic        ntram_a10
);
    logic [NUM_WIN-1:0][PAGE_W-1:0] bank_q;
    logic     dis_lo_q;
    logic     dis_hi_q;
    win_idx_t win_idx;
    page_t    cur_bank;

    chr_bank_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .bank_q   (bank_q),
        .dis_lo_q (dis_lo_q),
        .dis_hi_q (dis_hi_q)
    );

    chr_window_select u_win (
        .ppu_addr (ppu_addr),
        .win_idx  (win_idx)
    );

    // Pick the bank value of the addressed window.
    always_comb cur_bank = bank_q[win_idx];

    chr_bank_route u_route (
        .bank      (cur_bank),
        .win_idx   (win_idx),
        .dis_lo    (dis_lo_q),
        .dis_hi    (dis_hi_q),
        .rom_page  (rom_page),
        .rom_sel   (rom_sel),
        .ntram_sel (ntram_sel),
        .ntram_a10 (ntram_a10)
    );

    p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({rom_sel, ntram_sel}));

    p_low_rom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank < 8'hE0) |-> (rom_sel && rom_page == cur_bank));

    p_nt_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_addr[13] && cur_bank >= 8'hE0) |-> (ntram_sel && ntram_a10 == cur_bank[0]));
endmodule

// File: tb/chr_bank_selector_test.sv
module chr_bank_selector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [13:0] ppu_addr = '0;
    logic [7:0]  rom_page;
    logic        rom_sel, ntram_sel, ntram_a10;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_bank [12];
    logic exp_lo = 1'b0, exp_hi = 1'b0;

    chr_bank_selector uut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .ppu_addr(ppu_addr), .rom_page(rom_page),
        .rom_sel(rom_sel), .ntram_sel(ntram_sel), .ntram_a10(ntram_a10)
    );

    always #10 clk = ~clk;

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic we = 1'b1);
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_we = 1'b0;
        if (we && a[15] && a[14:11] <= 4'd11) exp_bank[a[14:11]] = d;
        if (we && a[15:11] == 5'b11101) begin exp_lo = d[6]; exp_hi = d[7]; end
    endtask

    // Expected outputs from the requirements for a given PPU address.
    task automatic probe(input logic [13:0] pa, input string req);
        int w;
        logic [7:0] b;
        logic allow, exp_nt;
        w = pa[13] ? 8 + int'(pa[11:10]) : int'(pa[12:10]);
        b = exp_bank[w];
        allow = (w >= 8) ? 1'b1 : (w < 4) ? !exp_lo : !exp_hi;
        exp_nt = (b >= 8'hE0) && allow;
        ppu_addr = pa;
        #1;
        tests++;
        if (ntram_sel !== exp_nt || rom_sel !== !exp_nt ||
            (!exp_nt && rom_page !== b) || (exp_nt && ntram_a10 !== b[0])) begin
            fails++;
            $display("FAIL %s ppu=%h: got rom_sel=%b nt=%b page=%h a10=%b, expected rom_sel=%b nt=%b page=%h a10=%b",
                     req, pa, rom_sel, ntram_sel, rom_page, ntram_a10, !exp_nt, exp_nt, b, b[0]);
        end
    endtask

    task automatic t_reset;   // R1
        for (int w = 0; w < 12; w++) begin
            @(negedge clk);
            probe(w < 8 ? 14'(w * 'h400) : 14'('h2000 + (w - 8) * 'h400), "R1");
        end
    endtask

    task automatic t_load_all;   // R2, R3, R8
        for (int w = 0; w < 12; w++)
            cpu_write(16'('h8000 + w * 'h800 + ((w % 2) ? 'h7FF : 0)), 8'(8'h10 + w * 7));
        for (int w = 0; w < 8; w++) begin
            @(negedge clk); probe(14'(w * 'h400 + 'h3FF), "R2");
        end
        for (int w = 0; w < 4; w++) begin
            @(negedge clk); probe(14'('h2000 + w * 'h400), "R3");
            @(negedge clk); probe(14'('h3000 + w * 'h400 + 'h12), "R8");
        end
    endtask

    task automatic t_low_high;   // R4, R5
        cpu_write(16'h8000, 8'hDF);
        @(negedge clk); probe(14'h0000, "R4");
        cpu_write(16'h9000, 8'hE0);
        cpu_write(16'hA800, 8'hE1);
        @(negedge clk); probe(14'h0800, "R5");
        @(negedge clk); probe(14'h1400, "R5");
    endtask

    task automatic t_disable;   // R6
        cpu_write(16'hE800, 8'h40);
        @(negedge clk); probe(14'h0800, "R6");
        @(negedge clk); probe(14'h1400, "R6");
        cpu_write(16'hEFFF, 8'h80);
        @(negedge clk); probe(14'h0800, "R6");
        @(negedge clk); probe(14'h1400, "R6");
        cpu_write(16'hE800, 8'hC0);
        @(negedge clk); probe(14'h0800, "R6");
        @(negedge clk); probe(14'h1400, "R6");
    endtask

    task automatic t_nametable;   // R7
        cpu_write(16'hC000, 8'hFE);
        cpu_write(16'hC800, 8'hE3);
        @(negedge clk); probe(14'h2000, "R7");
        @(negedge clk); probe(14'h2400, "R7");
        @(negedge clk); probe(14'h3400, "R7");
    endtask

    task automatic t_ignored;   // R9
        cpu_write(16'h7800, 8'h55);
        cpu_write(16'hE000, 8'h66);
        cpu_write(16'hF000, 8'h77);
        cpu_write(16'hF800, 8'h88);
        cpu_write(16'h8000, 8'h99, 1'b0);
        cpu_write(16'hE800, 8'h3F);
        for (int w = 0; w < 8; w++) begin
            @(negedge clk); probe(14'(w * 'h400), "R9");
        end
    endtask

    task automatic t_comb;   // R10
        @(posedge clk);
        #3 probe(14'h0000, "R10");
        #2 probe(14'h2400, "R10");
        #2 probe(14'h0C00, "R10");
    endtask

    initial begin
        for (int w = 0; w < 12; w++) exp_bank[w] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_all();
        t_low_high();
        t_disable();
        t_nametable();
        t_ignored();
        t_comb();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule